// File: doc/BRIEF.md
# PLL Loss-of-Lock Detector

This block reports whether a phase-locked loop has settled. A phase comparator outside the block raises a one-cycle slip pulse whenever the input and feedback clocks may have slipped a cycle relative to each other. Each slip pulse restarts a one-shot timer. The timer counts ticks from a slow timebase. While it runs, the block reports loss of lock. The PLL is called locked only after a full selected interval passes with no slip. Loss of lock is also held active for as long as the PLL reports that its calibration is running.

A 3-bit code selects the interval. Each step of the code halves the interval, and code 111 is the shortest. The shortest interval is a parameter given in timebase ticks. The block has two outputs. The status bit is always 1 for loss of lock. The pin level follows a polarity input.

Top module: `lock_loss_detect`

## Requirements
- R1: A cycle with `slipPulse` high loads the timer with the full interval of the current `timeSel`. `lossStatus` is then 1 for the following interval minus one tick and returns to 0 on the last tick.
- R2: The timer falls by exactly one per `tick` pulse. `lossStatus` returns to 0 only when the full interval has elapsed with no slip and no calibration.
- R3: Code k (0..7) selects `BASE_TICKS << (7-k)` ticks. With the default `BASE_TICKS` = 2, code 000 gives 256 ticks and code 111 gives 2 ticks.
- R4: After reset, `lossStatus` is 1 and the timer holds the interval of code `RST_SEL` (default 100, i.e. 16 ticks). The `timeSel` value present at reset has no effect on this.
- R5: While `calActive` is 1, `lossStatus` is 1 and ticks do not advance the timer. After `calActive` falls, a full interval of the current code must still elapse.
- R6: `lossPin` equals `lossStatus` when `pinActiveHigh` is 1, and equals its inverse when `pinActiveHigh` is 0.
- R7: A change of `timeSel` does not shorten or lengthen a running timer. The new code is used from the next slip onward.
- R8: When a slip and a tick arrive in the same cycle, the reload wins and that tick is not counted.
- R9: Ticks arriving while the timer has expired are ignored. The counter does not wrap, and `lossStatus` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slipPulse | input | 1 | Possible cycle slip seen, one cycle wide |
| calActive | input | 1 | PLL calibration is running |
| timeSel | input | 3 | Retrigger interval code |
| pinActiveHigh | input | 1 | 1: pin is high on loss; 0: pin is low on loss |
| tick | input | 1 | Timebase pulse, one cycle wide |
| lossPin | output | 1 | Loss-of-lock pin level |
| lossStatus | output | 1 | Loss-of-lock status bit, 1 for loss |

## Verification
The assertions check four things on every cycle:
- calibration always forces loss active;
- a slip is always followed by loss;
- the counter only ever holds, steps down by one, or reloads, and never exceeds the longest interval;
- the pin always matches the status under the chosen polarity.

Only the bench's scenarios can show the exact interval of each code and the reset interval. They also show that a code change leaves a running timer untouched, that a slip wins over a coincident tick, and that ticks are ignored once the timer has expired.

// File: rtl/lock_loss_pkg.sv
package lock_loss_pkg;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned CODES = 1 << SEL_W;

  typedef struct packed {
    logic load;
    logic dec;
  } tmrStrobe_t;

  // Interval in ticks: each code step halves it; the last code gives baseTicks.
  function automatic int unsigned ticksFor(int unsigned baseTicks, logic [SEL_W-1:0] sel);
    return baseTicks << (CODES - 1 - int'(sel));
  endfunction
endpackage

// File: rtl/lock_timer_dp.sv
module lock_timer_dp
  import lock_loss_pkg::*;
#(
  parameter int unsigned CNT_W   = 9,
  parameter int unsigned MAX_DUR = 256,
  parameter int unsigned RST_DUR = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmrStrobe_t       strb,
  input  logic [CNT_W-1:0] loadVal,
  output logic             expired
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          remain <= CNT_W'(RST_DUR);
    else if (strb.load)  remain <= loadVal;
    else if (strb.dec)   remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);

  // R2
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.load |=> (remain == $past(remain)) || (remain == $past(remain) - 1'b1));

  // R3
  max_dur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    remain <= CNT_W'(MAX_DUR));
endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl
  import lock_loss_pkg::*;
#(
  parameter int unsigned CNT_W      = 9,
  parameter int unsigned BASE_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slipPulse,
  input  logic             calActive,
  input  logic             tick,
  input  logic [SEL_W-1:0] timeSel,
  input  logic             expired,
  output tmrStrobe_t       strb,
  output logic [CNT_W-1:0] loadVal,
  output logic             lost
);
  always_comb begin
    // Calibration holds the timer at full length, so the interval starts when it ends.
    strb.load = slipPulse | calActive;
    strb.dec  = tick & ~expired;
    loadVal   = CNT_W'(ticksFor(BASE_TICKS, timeSel));
    lost      = ~expired | calActive;
  end

  // R5
  cal_forces_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    calActive |-> lost);

  // R1
  slip_gives_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slipPulse |=> lost);
endmodule

// File: rtl/lock_loss_detect.sv
module lock_loss_detect
  import lock_loss_pkg::*;
#(
  parameter int unsigned BASE_TICKS = 2,
  parameter int unsigned RST_SEL    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slipPulse,
  input  logic             calActive,
  input  logic [SEL_W-1:0] timeSel,
  input  logic             pinActiveHigh,
  input  logic             tick,
  output logic             lossPin,
  output logic             lossStatus
);
  localparam int unsigned MAX_DUR = BASE_TICKS << (CODES - 1);
  localparam int unsigned RST_DUR = BASE_TICKS << (CODES - 1 - RST_SEL);
  localparam int unsigned CNT_W   = $clog2(MAX_DUR + 1);

  tmrStrobe_t       strb;
  logic [CNT_W-1:0] loadVal;
  logic             expired;
  logic             lost;

  lock_ctrl #(.CNT_W(CNT_W), .BASE_TICKS(BASE_TICKS)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .slipPulse(slipPulse), .calActive(calActive),
    .tick(tick), .timeSel(timeSel), .expired(expired),
    .strb(strb), .loadVal(loadVal), .lost(lost)
  );

  lock_timer_dp #(.CNT_W(CNT_W), .MAX_DUR(MAX_DUR), .RST_DUR(RST_DUR)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .loadVal(loadVal), .expired(expired)
  );

  assign lossStatus = lost;
  assign lossPin    = pinActiveHigh ? lost : ~lost;

  // R6
  pin_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lossPin ^ lossStatus) == !pinActiveHigh);
endmodule

// File: tb/lock_loss_detect_tb.sv
module lock_loss_detect_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slipPulse = 1'b0, calActive = 1'b0, pinActiveHigh = 1'b1, tick = 1'b0;
  logic [2:0] timeSel = 3'b111;
  logic lossPin, lossStatus;
  int tests = 0, fails = 0;
  bit done = 0;

  localparam int unsigned BASE = 2;

  always #5 clk = ~clk;

  lock_loss_detect #(.BASE_TICKS(BASE), .RST_SEL(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .slipPulse(slipPulse), .calActive(calActive),
    .timeSel(timeSel), .pinActiveHigh(pinActiveHigh), .tick(tick),
    .lossPin(lossPin), .lossStatus(lossStatus)
  );

  function automatic int dur(logic [2:0] k);
    return BASE << (7 - int'(k));
  endfunction

  task automatic check(string req, logic got, logic exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic slip();
    @(negedge clk) slipPulse = 1'b1;
    @(negedge clk) slipPulse = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    // R4: timeSel at 111 during reset; interval of code 100 (16 ticks) still applies
    timeSel = 3'b111;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R4 reset active", lossStatus, 1'b1);
    rst_n = 1'b1;
    ticks(dur(3'b100) - 1);
    check("R4 still active at 15", lossStatus, 1'b1);
    ticks(1);
    check("R4 clear at 16", lossStatus, 1'b0);
  endtask

  task automatic t_codes();
    // R1 R2 R3: each code gives BASE << (7-k) ticks
    for (int k = 0; k < 8; k++) begin
      timeSel = 3'(k);
      slip();
      ticks(dur(3'(k)) - 1);
      check("R3 active before end", lossStatus, 1'b1);
      ticks(1);
      check("R1 clear at end", lossStatus, 1'b0);
    end
  endtask

  task automatic t_retrigger();
    // R2: a mid-interval slip restarts the full interval
    timeSel = 3'b101;
    slip();
    ticks(5);
    slip();
    ticks(dur(3'b101) - 1);
    check("R2 restarted", lossStatus, 1'b1);
    ticks(1);
    check("R2 clear", lossStatus, 1'b0);
  endtask

  task automatic t_selChange();
    // R7: a code change leaves the running timer unchanged
    timeSel = 3'b100;
    slip();
    timeSel = 3'b111;
    ticks(15);
    check("R7 not truncated", lossStatus, 1'b1);
    ticks(1);
    check("R7 ends at old interval", lossStatus, 1'b0);
    slip();
    ticks(1);
    check("R7 new code active", lossStatus, 1'b1);
    ticks(1);
    check("R7 new code clear", lossStatus, 1'b0);
  endtask

  task automatic t_cal();
    // R5: calibration forces loss and holds the timer at full length
    timeSel = 3'b110;
    @(negedge clk) calActive = 1'b1;
    ticks(20);
    check("R5 forced during cal", lossStatus, 1'b1);
    calActive = 1'b0;
    ticks(dur(3'b110) - 1);
    check("R5 full interval after cal", lossStatus, 1'b1);
    ticks(1);
    check("R5 clear", lossStatus, 1'b0);
  endtask

  task automatic t_coincide();
    // R8: the reload wins over a tick in the same cycle
    timeSel = 3'b110;
    @(negedge clk) begin slipPulse = 1'b1; tick = 1'b1; end
    @(negedge clk) begin slipPulse = 1'b0; tick = 1'b0; end
    ticks(dur(3'b110) - 1);
    check("R8 tick not counted", lossStatus, 1'b1);
    ticks(1);
    check("R8 clear", lossStatus, 1'b0);
  endtask

  task automatic t_idleTicks();
    // R9: ticks after expiry neither wrap the counter nor raise loss
    timeSel = 3'b111;
    ticks(5);
    check("R9 stays locked", lossStatus, 1'b0);
    slip();
    ticks(1);
    check("R9 timer intact", lossStatus, 1'b1);
    ticks(1);
    check("R9 clear", lossStatus, 1'b0);
  endtask

  task automatic t_polarity();
    // R6: the pin follows the status, inverted when pinActiveHigh is 0
    pinActiveHigh = 1'b1;
    @(negedge clk);
    check("R6 high-pol locked", lossPin, 1'b0);
    pinActiveHigh = 1'b0;
    @(negedge clk);
    check("R6 low-pol locked", lossPin, 1'b1);
    timeSel = 3'b111;
    slip();
    check("R6 low-pol loss", lossPin, 1'b0);
    pinActiveHigh = 1'b1;
    @(negedge clk);
    check("R6 high-pol loss", lossPin, 1'b1);
    ticks(2);
  endtask

  initial begin
    t_reset();
    t_codes();
    t_retrigger();
    t_selChange();
    t_cal();
    t_coincide();
    t_idleTicks();
    t_polarity();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule